// File: doc/BRIEF.md
# Two-Level Interrupt Mask Controller

This block collects up to thirty external level-sensitive interrupt sources and presents them to a processor as two request lines. One line is a normal request. The other is a fast request with higher priority. Each level keeps its own enable mask. Software reads a raw signal view and a masked status view of the sources, and chooses which level a source belongs to by setting it in one of the two masks. The hardware keeps the two masks disjoint, so a source enabled at one level is removed from the other.

Bit 0 of both levels reports the combined fast request, which lets software route that request into the normal line as well. Bit 1 of each level is a software-programmed request. These requests bypass the masks and are set and cleared through a configuration register. Source inputs 31 down to 2 pass through a two-flop synchronizer. The block does no priority encoding and generates no vectors. Peripherals withdraw their own requests.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, every readable register returns 0 and both `irq_o` and `fiq_o` are low.
- R2: Bits 31..2 of both signal registers (normal at word 0x0, fast at 0x4) equal `src_i[31:2]` as sampled two rising edges earlier, whatever the masks hold. `src_i[1:0]` has no effect anywhere.
- R3: Each status register (normal at 0x3, fast at 0x7) equals its signal register ANDed with its enable mask for bits 31..2 and bit 0. Status bit 1 equals signal bit 1 whatever the mask holds.
- R4: A write to an enable register (normal at 0x1, fast at 0x5) sets the bits written as 1. Bits written as 0 keep their value.
- R5: A write to a clear register (normal at 0x2, fast at 0x6) clears the matching bits of that level's enable mask and leaves the other bits unchanged. A clear register reads as 0.
- R6: `irq_o` is high exactly when any bit of the normal status register is 1.
- R7: Setting a bit in either enable mask clears the same bit in the other mask, so the two masks never share a 1. A bit may be 0 in both.
- R8: `fiq_o` is high exactly when any of bits 31..1 of the fast status register is 1. Bit 0 of both signal registers equals `fiq_o`.
- R9: The software configuration register at 0x8 holds two bits. Bit 2 drives bit 1 of the fast signal and status registers, and bit 1 drives bit 1 of the normal signal and status registers. All other bits read as 0 and are ignored on write.
- R10: Reads from word offsets 0x9 to 0xF return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive source requests; bits 1..0 unused |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal request to the processor |
| fiq_o | output | 1 | Fast request to the processor |

## Verification
A mask bit left standing after a clear, or a shared bit left in both masks after a set, shows on `irq_o` or `fiq_o` two edges after the matching source rises. It also shows at once when the mask or the other level's mask is read back. A synchronizer with the wrong depth shifts every signal-register and request transition by one cycle, which a per-clock comparison exposes at the first source edge. A wrong route for the software bits or the bit-0 fold changes the request line in the cycle after the configuration write.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam logic [ADDR_W-1:0] A_ISIG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ISTA = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FSIG = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_FEN  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_FSTA = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_SWI  = ADDR_W'(8);

  logic [31:2] sync1, sync2;
  logic [31:0] ien, fen;
  logic        swi_n, swi_f;
  logic        fiq_req;
  logic [31:0] isig, ista, fsig, fsta;
  logic        unused_src;

  assign unused_src = ^src_i[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      ien   <= '0;
      fen   <= '0;
      swi_n <= 1'b0;
      swi_f <= 1'b0;
    end else begin
      sync1 <= src_i[31:2];
      sync2 <= sync1;
      if (bus_we) begin
        case (bus_addr)
          A_IEN: begin
            ien <= ien | bus_wdata;
            fen <= fen & ~bus_wdata;
          end
          A_ICLR: ien <= ien & ~bus_wdata;
          A_FEN: begin
            fen <= fen | bus_wdata;
            ien <= ien & ~bus_wdata;
          end
          A_FCLR: fen <= fen & ~bus_wdata;
          A_SWI: begin
            swi_f <= bus_wdata[2];
            swi_n <= bus_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  assign fiq_req = |{sync2 & fen[31:2], swi_f};

  assign fsig = {sync2, swi_f, fiq_req};
  assign isig = {sync2, swi_n, fiq_req};
  assign fsta = {sync2 & fen[31:2], swi_f, fiq_req & fen[0]};
  assign ista = {sync2 & ien[31:2], swi_n, fiq_req & ien[0]};

  assign irq_o = |ista;
  assign fiq_o = fiq_req;

  always_comb begin
    case (bus_addr)
      A_ISIG:  bus_rdata = isig;
      A_IEN:   bus_rdata = ien;
      A_ISTA:  bus_rdata = ista;
      A_FSIG:  bus_rdata = fsig;
      A_FEN:   bus_rdata = fen;
      A_FSTA:  bus_rdata = fsta;
      A_SWI:   bus_rdata = {29'd0, swi_f, swi_n, 1'b0};
      default: bus_rdata = '0;
    endcase
  end

  assert_masks_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien & fen) == 32'd0);

  assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_IEN) |=> ((ien & $past(bus_wdata)) == $past(bus_wdata)));

  assert_en_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_FCLR) |=> ((fen & $past(bus_wdata)) == 32'd0));

  assert_swi_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SWI && bus_wdata[2]) |=> fiq_o);

  assert_clear_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ICLR) |=> ((ien & ~$past(bus_wdata)) == ($past(ien) & ~$past(bus_wdata))));

endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_mask_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // Behavioural reference: a queue of source samples and plain mask words
  logic [31:0] srcq[$];
  logic [31:0] m_ien, m_fen;
  bit          m_swn, m_swf;

  function automatic logic [31:0] m_src();
    return srcq.size() >= 2 ? srcq[0] : 32'd0;
  endfunction

  function automatic bit m_fiq();
    logic [31:0] s = m_src();
    bit r = m_swf;
    for (int b = 2; b < 32; b++) if (s[b] && m_fen[b]) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] m_sig(bit fast);
    logic [31:0] s = m_src();
    logic [31:0] v = '0;
    for (int b = 2; b < 32; b++) v[b] = s[b];
    v[1] = fast ? m_swf : m_swn;
    v[0] = m_fiq();
    return v;
  endfunction

  function automatic logic [31:0] m_sta(bit fast);
    logic [31:0] sg = m_sig(fast);
    logic [31:0] en = fast ? m_fen : m_ien;
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) v[b] = (b == 1) ? sg[b] : (sg[b] && en[b]);
    return v;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_sig(0);
      4'd1: return m_ien;
      4'd3: return m_sta(0);
      4'd4: return m_sig(1);
      4'd5: return m_fen;
      4'd7: return m_sta(1);
      4'd8: return {29'd0, m_swf, m_swn, 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcq = {};
      m_ien = '0; m_fen = '0; m_swn = 0; m_swf = 0;
    end else begin
      srcq.push_back(src_i);
      if (srcq.size() > 2) void'(srcq.pop_front());
      if (bus_we) begin
        case (bus_addr)
          4'd1: begin m_ien = m_ien | bus_wdata; m_fen = m_fen & ~bus_wdata; end
          4'd2: m_ien = m_ien & ~bus_wdata;
          4'd5: begin m_fen = m_fen | bus_wdata; m_ien = m_ien & ~bus_wdata; end
          4'd6: m_fen = m_fen & ~bus_wdata;
          4'd8: begin m_swf = bus_wdata[2]; m_swn = bus_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(logic [3:0] a);
    case (a)
      4'd0, 4'd4: return "R2";
      4'd1, 4'd5: return "R4";
      4'd2, 4'd6: return "R5";
      4'd3, 4'd7: return "R3";
      4'd8:       return "R9";
      default:    return "R10";
    endcase
  endfunction

  // Per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6", {31'd0, irq_o}, {31'd0, (m_sta(0) != 0)});
      check("R8", {31'd0, fiq_o}, {31'd0, m_fiq()});
      check(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(logic [3:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic set_src(logic [31:0] v);
    @(posedge clk); #2;
    src_i = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    src_i = 32'hFFFF_FFFF;
    idle(3);
    src_i = '0;
    #2; rst_n = 1'b1;
    // R1: everything zero out of reset
    for (int a = 0; a < 16; a++) rd_expect(4'(a), 32'd0, "R1");
    @(negedge clk);
    check("R1", {30'd0, irq_o, fiq_o}, 32'd0);

    // R2: raw signals follow sources with masks clear; bits 1..0 ignored
    set_src(32'hA5A5_0003);
    @(posedge clk); #2; bus_addr = 4'd0;
    @(negedge clk); check("R2", bus_rdata, 32'd0);
    @(negedge clk); check("R2", bus_rdata, 32'hA5A5_0000);
    rd_expect(4'd3, 32'd0, "R3");

    // R4/R3/R6: enable normal bits
    wr(4'd1, 32'h0000_0004);
    wr(4'd1, 32'h8000_0000);
    rd_expect(4'd1, 32'h8000_0004, "R4");
    rd_expect(4'd3, 32'h8000_0000, "R3");
    @(negedge clk); check("R6", {31'd0, irq_o}, 32'd1);

    // R7: fast enable steals bit 31
    wr(4'd5, 32'h8000_0100);
    rd_expect(4'd1, 32'h0000_0004, "R7");
    rd_expect(4'd5, 32'h8000_0100, "R7");
    @(negedge clk); check("R8", {30'd0, irq_o, fiq_o}, 32'd1);
    rd_expect(4'd0, 32'hA5A5_0001, "R8");

    // R3: bit 0 fold routed into normal level
    wr(4'd1, 32'h0000_0001);
    rd_expect(4'd3, 32'h0000_0001, "R3");
    @(negedge clk); check("R6", {31'd0, irq_o}, 32'd1);

    // R5: clear registers
    wr(4'd6, 32'h8000_0000);
    rd_expect(4'd5, 32'h0000_0100, "R5");
    rd_expect(4'd6, 32'd0, "R5");
    wr(4'd2, 32'h0000_0001);
    rd_expect(4'd1, 32'h0000_0004, "R5");
    wr(4'd2, 32'h0000_0004);
    rd_expect(4'd1, 32'd0, "R7");
    rd_expect(4'd5, 32'h0000_0100, "R7");

    // R9: software requests bypass masks
    wr(4'd8, 32'hFFFF_FFFF);
    rd_expect(4'd8, 32'h0000_0006, "R9");
    rd_expect(4'd7, 32'h0000_0002, "R9");
    rd_expect(4'd3, 32'h0000_0002, "R9");
    @(negedge clk); check("R9", {30'd0, irq_o, fiq_o}, 32'd3);
    wr(4'd8, 32'h0000_0002);
    @(negedge clk); check("R9", {30'd0, irq_o, fiq_o}, 32'd2);
    wr(4'd8, 32'd0);

    // R10: unmapped writes ignored
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd_expect(4'd9, 32'd0, "R10");
    rd_expect(4'd1, 32'd0, "R10");
    rd_expect(4'd5, 32'h0000_0100, "R10");

    // walking sources with mixed masks; per-clock reference does the checking
    wr(4'd5, 32'h0F0F_0000);
    wr(4'd1, 32'h00FF_0000);
    for (int b = 0; b < 32; b++) begin
      set_src(32'd1 << b);
      idle(3);
    end
    set_src(32'h3333_3333);
    idle(4);
    set_src(32'd0);
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule